// File: doc/BRIEF.md
# Tape Record DMA Read Engine

This block is the register file and transfer engine of a magnetic tape controller. It copies a single record from the tape into system memory. Software sets up three 16-bit registers over a small word-addressed register bus: a memory address, a byte counter and a command word. The byte counter is loaded with the negative of the number of bytes wanted. Writing the command word with its start bit set and the read function selected begins the transfer, and the processor takes no further part in it.

While a transfer is active the engine takes one byte at a time from a tape-side byte stream, using a valid/ready handshake that carries an end-of-record flag. Each byte becomes one byte write on a DMA master port, which also uses a valid/ready handshake. Every accepted write increments both the address register and the counter. The transfer stops when the counter reaches zero or when the byte marked as the end of the record has been written, whichever comes first. A count larger than the record therefore reads exactly the whole record. A ready bit in the command word tells software when the engine is idle again.

Top module: `tape_dma_reader`

## Requirements
- R1: The registers are selected by the byte offset on `regAddr`: command at 0, byte counter at 2, memory address at 4. After reset the command word reads 16'h0080 (only the ready bit set), and the counter and address both read 0.
- R2: In the command word, bit 0 is the start bit, bits 3:1 are the function code and bits 14:13 are the density code, and bit 7 is a read-only ready bit. Function and density read back as written. The start bit always reads 0, so a command write of 16'h6003 reads back as 16'h6082 once the engine is idle.
- R3: A command write with bit 0 set and function code 3'b001 (read), made while the engine is idle and the counter is nonzero, starts a transfer. The ready bit reads 0 from the next cycle until the transfer ends.
- R4: A command write with the start bit set and any function code other than 3'b001 starts nothing. No tape byte is taken, no DMA write is issued and the ready bit stays 1.
- R5: Each byte taken from the tape produces exactly one DMA write. The write carries that byte, and its address is the value of the memory address register. `dmaAddr` and `dmaData` are held stable while `dmaValid` is high and `dmaReady` is low.
- R6: Each accepted DMA write increments the memory address register and the counter by one, modulo 2^16. The address wraps from 16'hFFFF to 16'h0000.
- R7: The transfer ends after the write that brings the counter to zero. The engine takes no further tape bytes, and the counter then reads 0.
- R8: The transfer ends after the write of a byte that arrived with `tapeLast` high, even if the counter is still nonzero. The counter then reads the negative of the bytes still outstanding.
- R9: A read start with the counter at zero transfers nothing, and the ready bit stays 1.
- R10: Register writes made while a transfer is active are ignored. This includes a second start command, and it leaves the counter, the address and the running transfer unaffected.
- R11: `tapeReady` is high only while the engine holds no byte, so `tapeReady` and `dmaValid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register byte offset (0, 2 or 4) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data of the register at `regAddr` (combinational) |
| tapeValid | input | 1 | Tape byte available |
| tapeData | input | 8 | Tape byte |
| tapeLast | input | 1 | This byte is the last of the record |
| tapeReady | output | 1 | Engine accepts a tape byte |
| dmaValid | output | 1 | DMA byte write request |
| dmaAddr | output | 16 | DMA byte address |
| dmaData | output | 8 | DMA write byte |
| dmaReady | input | 1 | Memory accepts the write |

## Verification
The bench sweeps every pairing of requested count and record length up to five bytes, with stalls on both handshakes. The race between the counter end and the record end is covered from both sides, and so is the tie. An engine that misses the record end writes stray bytes past the record. One that takes its end test from the counter before the increment writes one byte too many or too few, and that shows in the write log and in the final counter. A zero count and a start under a non-read function must leave ready high with no traffic, where a careless engine would transfer 65536 bytes or run an unknown function. Register writes and a second start during a slow transfer must change neither the address sequence nor the final register values, and a start from an address near 16'hFFFF must wrap to zero.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  typedef struct packed {
    logic busy;
    logic loadByte;
    logic advance;
  } tdr_strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WRITE} tdr_state_t;

  localparam logic [2:0] OFF_CMD   = 3'd0;
  localparam logic [2:0] OFF_CNT   = 3'd2;
  localparam logic [2:0] OFF_ADDR  = 3'd4;
  localparam int         GO_BIT    = 0;
  localparam int         FUNC_LSB  = 1;
  localparam int         FUNC_W    = 3;
  localparam int         READY_BIT = 7;
  localparam int         DENS_LSB  = 13;
  localparam int         DENS_W    = 2;
  localparam logic [FUNC_W-1:0] FUNC_READ = 3'b001;
endpackage

// File: rtl/tdr_datapath.sv
module tdr_datapath
  import tdr_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    regAddr,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWrData,
  input  tdr_strobe_t   strb,
  input  logic          readyIn,
  input  logic [BW-1:0] tapeData,
  input  logic          tapeLast,
  output logic [DW-1:0] regRdData,
  output logic [DW-1:0] curAddr,
  output logic [DW-1:0] curCnt,
  output logic [BW-1:0] byteOut,
  output logic          lastFlag,
  output logic          cntZero,
  output logic          cntLast
);
  logic [FUNC_W-1:0] funcReg;
  logic [DENS_W-1:0] densReg;
  logic [DW-1:0]     addrReg;
  logic [DW-1:0]     cntReg;
  logic [BW-1:0]     byteReg;
  logic              lastReg;
  logic              hostWr;

  assign hostWr = regWrEn && !strb.busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      funcReg <= '0;
      densReg <= '0;
      addrReg <= '0;
      cntReg  <= '0;
      byteReg <= '0;
      lastReg <= 1'b0;
    end else begin
      if (hostWr) begin
        case (regAddr)
          OFF_CMD: begin
            funcReg <= regWrData[FUNC_LSB +: FUNC_W];
            densReg <= regWrData[DENS_LSB +: DENS_W];
          end
          OFF_CNT:  cntReg  <= regWrData;
          OFF_ADDR: addrReg <= regWrData;
          default: ;
        endcase
      end
      if (strb.loadByte) begin
        byteReg <= tapeData;
        lastReg <= tapeLast;
      end
      if (strb.advance) begin
        addrReg <= addrReg + DW'(1);
        cntReg  <= cntReg + DW'(1);
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFF_CMD: begin
        regRdData[FUNC_LSB +: FUNC_W] = funcReg;
        regRdData[DENS_LSB +: DENS_W] = densReg;
        regRdData[READY_BIT]          = readyIn;
      end
      OFF_CNT:  regRdData = cntReg;
      OFF_ADDR: regRdData = addrReg;
      default:  regRdData = '0;
    endcase
  end

  assign curAddr  = addrReg;
  assign curCnt   = cntReg;
  assign byteOut  = byteReg;
  assign lastFlag = lastReg;
  assign cntZero  = (cntReg == '0);
  assign cntLast  = (cntReg == '1);

  // R10: host writes during a transfer leave address and counter alone
  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && regWrEn && !strb.advance) |=> ($stable(addrReg) && $stable(cntReg)));
endmodule

// File: rtl/tdr_control.sv
module tdr_control
  import tdr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [3:0]  cmdLow,
  input  logic        tapeValid,
  input  logic        dmaReady,
  input  logic        cntZero,
  input  logic        cntLast,
  input  logic        lastFlag,
  output tdr_strobe_t strb,
  output logic        tapeReady,
  output logic        dmaValid,
  output logic        ready
);
  tdr_state_t state, stateNext;
  logic       goRead;

  assign goRead = regWrEn && (regAddr == OFF_CMD) && cmdLow[GO_BIT]
                  && (cmdLow[FUNC_LSB +: FUNC_W] == FUNC_READ);

  always_comb begin
    stateNext     = state;
    strb.busy     = (state != ST_IDLE);
    strb.loadByte = 1'b0;
    strb.advance  = 1'b0;
    case (state)
      ST_IDLE:  if (goRead && !cntZero) stateNext = ST_FETCH;
      ST_FETCH: if (tapeValid) begin
        strb.loadByte = 1'b1;
        stateNext     = ST_WRITE;
      end
      ST_WRITE: if (dmaReady) begin
        strb.advance = 1'b1;
        stateNext    = (cntLast || lastFlag) ? ST_IDLE : ST_FETCH;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign tapeReady = (state == ST_FETCH);
  assign dmaValid  = (state == ST_WRITE);
  assign ready     = (state == ST_IDLE);

  // R8: a write of the record's final byte returns the engine to idle
  assert_record_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dmaValid && dmaReady && lastFlag) |=> ready);
endmodule

// File: rtl/tape_dma_reader.sv
module tape_dma_reader
  import tdr_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    regAddr,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  input  logic          tapeValid,
  input  logic [BW-1:0] tapeData,
  input  logic          tapeLast,
  output logic          tapeReady,
  output logic          dmaValid,
  output logic [DW-1:0] dmaAddr,
  output logic [BW-1:0] dmaData,
  input  logic          dmaReady
);
  tdr_strobe_t   strb;
  logic          ready, cntZero, cntLast, lastFlag;
  logic [DW-1:0] curAddr, curCnt;
  logic          startCmd;

  tdr_control u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .cmdLow(regWrData[3:0]), .tapeValid(tapeValid), .dmaReady(dmaReady),
    .cntZero(cntZero), .cntLast(cntLast), .lastFlag(lastFlag),
    .strb(strb), .tapeReady(tapeReady), .dmaValid(dmaValid), .ready(ready)
  );

  tdr_datapath #(.DW(DW), .BW(BW)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .strb(strb), .readyIn(ready),
    .tapeData(tapeData), .tapeLast(tapeLast), .regRdData(regRdData),
    .curAddr(curAddr), .curCnt(curCnt), .byteOut(dmaData),
    .lastFlag(lastFlag), .cntZero(cntZero), .cntLast(cntLast)
  );

  assign dmaAddr = curAddr;

  assign startCmd = regWrEn && (regAddr == OFF_CMD) && regWrData[GO_BIT]
                    && (regWrData[FUNC_LSB +: FUNC_W] == FUNC_READ) && ready;

  // R3: an accepted read start with a nonzero count drops ready next cycle
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && (curCnt != '0)) |=> !ready);
  // R9: a read start with a zero count keeps the engine idle
  assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && (curCnt == '0)) |=> ready);
  // R5: a stalled write holds its address and data
  assert_hold_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dmaValid && !dmaReady) |=> (dmaValid && $stable(dmaAddr) && $stable(dmaData)));
  // R6: an accepted write steps address and counter by one
  assert_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dmaValid && dmaReady) |=> ((curAddr == $past(dmaAddr) + DW'(1))
                                && (curCnt == $past(curCnt) + DW'(1))));
  // R7: the write that reaches a zero count ends the transfer
  assert_count_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dmaValid && dmaReady && (curCnt == '1)) |=> (ready && (curCnt == '0)));
  // R11: never ask for a byte while one is waiting to be written
  assert_one_byte_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(tapeReady && dmaValid));
endmodule

// File: tb/tape_dma_reader_tb.sv
`timescale 1ns/1ps
module tape_dma_reader_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        tapeValid = 1'b0, tapeLast = 1'b0, tapeReady;
  logic [7:0]  tapeData = '0;
  logic        dmaValid, dmaReady = 1'b0;
  logic [15:0] dmaAddr;
  logic [7:0]  dmaData;

  tape_dma_reader u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .tapeValid(tapeValid),
    .tapeData(tapeData), .tapeLast(tapeLast), .tapeReady(tapeReady),
    .dmaValid(dmaValid), .dmaAddr(dmaAddr), .dmaData(dmaData),
    .dmaReady(dmaReady)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  int cyc = 0, runNo = 0, seenRun = 0, recLen = 0, k = 0, nWr = 0, bothHigh = 0;
  bit slow = 1'b0, pendTape = 1'b0, pendDma = 1'b0;
  logic [15:0] pAddr;
  logic [7:0]  pData;
  logic [15:0] logAddr [0:63];
  logic [7:0]  logData [0:63];

  function automatic logic [7:0] tbyte(int idx, int run);
    return 8'((idx * 37 + run * 11 + 5) % 256);
  endfunction

  // tape source, DMA sink and write log, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (seenRun != runNo) begin
      seenRun = runNo; k = 0; nWr = 0;
    end else begin
      if (pendTape) k++;
      if (pendDma) begin
        if (nWr < 64) begin logAddr[nWr] = pAddr; logData[nWr] = pData; end
        nWr++;
      end
    end
    if (tapeReady && dmaValid) bothHigh++;
    tapeValid = (k < recLen) && ((cyc + runNo) % 3 != 0);
    tapeData  = tbyte(k, runNo);
    tapeLast  = (k == recLen - 1);
    dmaReady  = slow ? (cyc % 4 == 0) : ((cyc * 5 + runNo) % 4 != 1);
    pendTape  = tapeValid && tapeReady;
    pendDma   = dmaValid && dmaReady;
    pAddr = dmaAddr; pData = dmaData;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] off, logic [15:0] d);
    @(negedge clk); #1;
    regAddr = off; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] off, output logic [15:0] d);
    #1; regAddr = off; #1; d = regRdData;
  endtask

  task automatic waitReady(string req);
    logic [15:0] v;
    int t = 0;
    do begin
      @(negedge clk); rd(3'd0, v); t++;
    end while (!v[7] && t < 3000);
    chk(v[7], req, "ready after transfer", v[7], 1);
  endtask

  task automatic runOne(logic [15:0] base, int n, int len);
    logic [15:0] v;
    int m;
    recLen = len; runNo++;
    @(negedge clk);
    wr(3'd4, base);
    wr(3'd2, 16'(-n));
    wr(3'd0, 16'h6003);
    waitReady("R3");
    m = (n == 0) ? 0 : ((n < len) ? n : len);
    chk(nWr == m, (n == 0) ? "R9" : ((n < len) ? "R7" : "R8"), "write count", nWr, m);
    for (int i = 0; i < m && i < 64; i++) begin
      chk(logAddr[i] == 16'(base + i), "R5", "dma address", logAddr[i], 16'(base + i));
      chk(logData[i] == tbyte(i, runNo), "R5", "dma data", logData[i], tbyte(i, runNo));
    end
    rd(3'd2, v);
    chk(v == 16'(m - n), (n <= len) ? "R7" : "R8", "final counter", v, 16'(m - n));
    rd(3'd4, v);
    chk(v == 16'(base + m), "R6", "final address", v, 16'(base + m));
    rd(3'd0, v);
    chk(v == 16'h6082, "R2", "command readback", v, 16'h6082);
  endtask

  initial begin : wdog
    #(200000 * 5);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at each offset
    rd(3'd0, v); chk(v == 16'h0080, "R1", "reset command", v, 16'h0080);
    rd(3'd2, v); chk(v == 16'h0000, "R1", "reset counter", v, 0);
    rd(3'd4, v); chk(v == 16'h0000, "R1", "reset address", v, 0);
    chk(!dmaValid && !tapeReady, "R1", "reset handshakes", {dmaValid, tapeReady}, 0);

    // R4: non-read function with go does nothing
    recLen = 4; runNo++;
    @(negedge clk);
    wr(3'd2, 16'hFFFD);
    wr(3'd0, 16'h6005);
    repeat (10) @(negedge clk);
    chk(nWr == 0, "R4", "no writes", nWr, 0);
    chk(k == 0, "R4", "no tape bytes", k, 0);
    rd(3'd0, v); chk(v == 16'h6084, "R4", "ready and fields", v, 16'h6084);
    rd(3'd2, v); chk(v == 16'hFFFD, "R4", "counter kept", v, 16'hFFFD);

    // sweep counts against record lengths
    for (int n = 0; n <= 5; n++)
      for (int len = 1; len <= 5; len++)
        runOne(16'(16'h0100 * n + 16'h0010 * len), n, len);

    // R6: address wrap
    runOne(16'hFFFE, 4, 6);

    // R10: writes during a slow transfer are ignored
    slow = 1'b1; recLen = 30; runNo++;
    @(negedge clk);
    wr(3'd4, 16'h0400);
    wr(3'd2, 16'(-20));
    wr(3'd0, 16'h6003);
    repeat (5) @(negedge clk);
    wr(3'd2, 16'h0000);
    wr(3'd4, 16'h1234);
    wr(3'd0, 16'h0003);
    wr(3'd0, 16'h0000);
    waitReady("R10");
    chk(nWr == 20, "R10", "write count", nWr, 20);
    for (int i = 0; i < 20; i++)
      chk(logAddr[i] == 16'(16'h0400 + i), "R10", "dma address", logAddr[i], 16'(16'h0400 + i));
    rd(3'd2, v); chk(v == 16'h0000, "R10", "final counter", v, 0);
    rd(3'd4, v); chk(v == 16'h0414, "R10", "final address", v, 16'h0414);
    rd(3'd0, v); chk(v == 16'h6082, "R10", "command unchanged", v, 16'h6082);
    slow = 1'b0;

    chk(bothHigh == 0, "R11", "tapeReady with dmaValid", bothHigh, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule